// File: doc/BRIEF.md
# PC/AT System Control Port with NMI Gating

This block holds the PC/AT miscellaneous system control port and the gate in front of the non-maskable interrupt. The port is one 8-bit I/O location. Its lower half holds four writable controls: the gate for timer channel 2, the speaker data enable, and separate enables for the parity-error and channel-check NMI sources. Its upper half is read-only and gives the latched error flags, the live timer-2 output and a toggle that flips on every memory refresh tick.

A second I/O location holds the master NMI mask. While its bit 7 is 1, no NMI reaches the CPU, whatever the per-source enables are. Error events arrive as one-cycle pulses and are latched at all times. A latched flag raises the NMI output only when its source enable is set and the master mask is clear. Software clears a flag by writing 1 to that source's enable bit. The speaker output is the timer-2 waveform gated by the speaker data enable, so holding the timer output high lets the register bit drive the speaker directly.

Top module: `pcat_sysctl`

## Requirements
- R1: After reset, all four control bits are 0, both error flags are 0, the refresh toggle is 0, the master mask reads as 1 (NMI blocked) and `nmi_out` is 0.
- R2: A write to the control port (default address 0x061) stores `io_wdata[3:0]` as the control bits. Bit 0 is the timer-2 gate, bit 1 the speaker enable, bit 2 the parity NMI enable and bit 3 the channel-check NMI enable. A read returns them in `io_rdata[3:0]`. Written values of bits 7:4 are ignored.
- R3: `tmr2_gate` equals control bit 0.
- R4: `spk_out` equals `tmr2_out` AND control bit 1.
- R5: A `parity_evt` pulse sets the parity flag on the next clock, and the flag reads as bit 7 of the control port. A control-port write with bit 2 set clears the flag. If an event and a clear fall in the same cycle, the event wins. Otherwise the flag holds.
- R6: A `chan_evt` pulse sets the channel-check flag, which reads as bit 6. The flag is cleared by a control-port write with bit 3 set, under the same priority as R5.
- R7: Bit 5 of the control-port read shows the present `tmr2_out`. Bit 4 shows a toggle that inverts on every clock in which `refresh_tick` is 1.
- R8: `nmi_out` is 1 exactly when the master mask is 0 and at least one latched flag has its enable bit set.
- R9: A write to the mask port (default address 0x070) stores `io_wdata[7]` as the master mask, where 1 blocks NMI. A read of that port returns the mask in bit 7 and 0 in bits 6:0.
- R10: A write to any other address changes no state. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| tmr2_out | input | 1 | Output of timer channel 2 |
| parity_evt | input | 1 | Parity error event pulse |
| chan_evt | input | 1 | Channel check event pulse |
| refresh_tick | input | 1 | Refresh tick pulse |
| tmr2_gate | output | 1 | Gate for timer channel 2 |
| spk_out | output | 1 | Speaker output |
| nmi_out | output | 1 | NMI request to the CPU |

## Verification
The hardest case to reach is a flag whose clear and a new event land in the same clock. With independent random inputs this is rare, and the outcome is easy to mask because the event may simply set the flag again a cycle later. The stimulus covers it with directed steps. One step writes bit 2 or bit 3 while the matching event pulses. Another sets a flag, enables it and then lifts the master mask, so that the NMI output rises only at the mask write. The random phase makes events and clearing writes frequent, so both priorities recur many times.

// File: rtl/pcat_sysctl_pkg.sv
package pcat_sysctl_pkg;
   // control nibble bit positions (software visible)
   localparam int CB_T2GATE = 0;
   localparam int CB_SPKEN  = 1;
   localparam int CB_PAREN  = 2;
   localparam int CB_CHKEN  = 3;
   // status nibble bit positions
   localparam int SB_TGL    = 4;
   localparam int SB_T2OUT  = 5;
   localparam int SB_CHK    = 6;
   localparam int SB_PAR    = 7;
   // mask port bit position
   localparam int MB_NMIDIS = 7;
   localparam int NSRC      = 2;   // index 0 = parity, 1 = channel check

   typedef struct packed {
      logic chk_en;
      logic par_en;
      logic spk_en;
      logic t2_gate;
   } ctrl_t;
endpackage

// File: rtl/sysctl_portb_regs.sv
module sysctl_portb_regs
   import pcat_sysctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  ctrl_t            wr_ctrl,
   input  logic [NSRC-1:0]  src_evt,
   input  logic             refresh_tick,
   output ctrl_t            ctrl,
   output logic [NSRC-1:0]  src_flag,
   output logic             refresh_tgl
);
   logic [NSRC-1:0] clr_req;

   assign clr_req = {wr_ctrl.chk_en, wr_ctrl.par_en};

   always_ff @(posedge clk) begin
      if (!rst_n)      ctrl <= '0;
      else if (wr_en)  ctrl <= wr_ctrl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            refresh_tgl <= 1'b0;
      else if (refresh_tick) refresh_tgl <= ~refresh_tgl;
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n)                       src_flag[g] <= 1'b0;
         else if (src_evt[g])              src_flag[g] <= 1'b1;  // event beats clear
         else if (wr_en && clr_req[g])     src_flag[g] <= 1'b0;
      end

      p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
         src_evt[g] |=> src_flag[g]);
      p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_evt[g] && !(wr_en && clr_req[g])) |=> $stable(src_flag[g]));
   end

   p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl));
   p_tgl_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_tick |=> (refresh_tgl != $past(refresh_tgl)));
   p_tgl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_tick |=> $stable(refresh_tgl));
endmodule

// File: rtl/sysctl_nmi_gate.sv
module sysctl_nmi_gate
   import pcat_sysctl_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_wr,
   input  logic             mask_val,
   input  logic [NSRC-1:0]  src_flag,
   input  logic [NSRC-1:0]  src_en,
   output logic             nmi_dis,
   output logic             nmi_out
);
   logic nmi_req;

   always_ff @(posedge clk) begin
      if (!rst_n)       nmi_dis <= 1'b1;
      else if (mask_wr) nmi_dis <= mask_val;
   end

   assign nmi_req = !nmi_dis && |(src_flag & src_en);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) nmi_out <= 1'b0;
         else        nmi_out <= nmi_req;
      end
   end else begin : g_comb
      assign nmi_out = nmi_req;
   end

   p_master_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_dis && $past(nmi_dis)) |-> !nmi_out);
   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(nmi_dis));
endmodule

// File: rtl/pcat_sysctl.sv
module pcat_sysctl
   import pcat_sysctl_pkg::*;
#(
   parameter int          ADDR_W      = 10,
   parameter logic [15:0] CTRL_ADDR   = 16'h0061,
   parameter logic [15:0] MASK_ADDR   = 16'h0070,
   parameter bit          NMI_REG_OUT = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              tmr2_out,
   input  logic              parity_evt,
   input  logic              chan_evt,
   input  logic              refresh_tick,
   output logic              tmr2_gate,
   output logic              spk_out,
   output logic              nmi_out
);
   localparam logic [ADDR_W-1:0] A_CTRL = CTRL_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_MASK = MASK_ADDR[ADDR_W-1:0];

   if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_width
      $error("pcat_sysctl: ADDR_W must lie in 7..16");
   end
   if (A_CTRL == A_MASK) begin : g_bad_map
      $error("pcat_sysctl: control and mask ports overlap");
   end

   logic             hit_ctrl, hit_mask;
   ctrl_t            ctrl;
   logic [NSRC-1:0]  src_flag;
   logic             refresh_tgl;
   logic             nmi_dis;

   assign hit_ctrl = (io_addr == A_CTRL);
   assign hit_mask = (io_addr == A_MASK);

   sysctl_portb_regs u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (io_wr && hit_ctrl),
      .wr_ctrl      (ctrl_t'(io_wdata[3:0])),
      .src_evt      ({chan_evt, parity_evt}),
      .refresh_tick (refresh_tick),
      .ctrl         (ctrl),
      .src_flag     (src_flag),
      .refresh_tgl  (refresh_tgl)
   );

   sysctl_nmi_gate #(.REG_OUT(NMI_REG_OUT)) u_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_wr  (io_wr && hit_mask),
      .mask_val (io_wdata[MB_NMIDIS]),
      .src_flag (src_flag),
      .src_en   ({ctrl.chk_en, ctrl.par_en}),
      .nmi_dis  (nmi_dis),
      .nmi_out  (nmi_out)
   );

   assign tmr2_gate = ctrl.t2_gate;
   assign spk_out   = tmr2_out & ctrl.spk_en;

   always_comb begin
      io_rdata = '0;
      if (hit_ctrl) begin
         io_rdata[3:0]    = ctrl;
         io_rdata[SB_TGL]   = refresh_tgl;
         io_rdata[SB_T2OUT] = tmr2_out;
         io_rdata[SB_CHK]   = src_flag[1];
         io_rdata[SB_PAR]   = src_flag[0];
      end else if (hit_mask) begin
         io_rdata[MB_NMIDIS] = nmi_dis;
      end
   end

   p_spk_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.spk_en |-> !spk_out);
   p_nmi_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_flag == '0 && $past(src_flag) == '0) |-> !nmi_out);
endmodule

// File: tb/sim_pcat_sysctl.sv
module sim_pcat_sysctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] io_addr = '0;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic       tmr2_out = 1'b0, parity_evt = 1'b0, chan_evt = 1'b0, refresh_tick = 1'b0;
   logic       tmr2_gate, spk_out, nmi_out;

   int n_chk = 0, n_err = 0;

   // model state
   logic [3:0] m_ctrl;
   logic       m_par, m_chk, m_tgl, m_dis;

   always #10 clk = ~clk;   // 50 MHz

   pcat_sysctl u0 (.*);

   function automatic logic [7:0] exp_rd(input logic [9:0] a);
      if (a == 10'h061) return {m_par, m_chk, tmr2_out, m_tgl, m_ctrl};
      if (a == 10'h070) return {m_dis, 7'b0};
      return 8'h00;
   endfunction

   function automatic logic exp_nmi();
      return !m_dis && ((m_par && m_ctrl[2]) || (m_chk && m_ctrl[3]));
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all();
      chk(tmr2_gate == m_ctrl[0], "R3", {7'b0, tmr2_gate}, {7'b0, m_ctrl[0]});
      chk(spk_out == (tmr2_out & m_ctrl[1]), "R4", {7'b0, spk_out}, {7'b0, tmr2_out & m_ctrl[1]});
      chk(nmi_out == exp_nmi(), "R8", {7'b0, nmi_out}, {7'b0, exp_nmi()});
      chk(io_rdata == exp_rd(io_addr),
          (io_addr == 10'h061) ? "R2 R5 R6 R7" : (io_addr == 10'h070) ? "R9" : "R10",
          io_rdata, exp_rd(io_addr));
   endtask

   // drive at negedge, clock, update model, check at next negedge
   task automatic step(input logic [9:0] a, input logic w, input logic [7:0] d,
                       input logic pe, input logic ce, input logic rt, input logic t2);
      io_addr = a; io_wr = w; io_wdata = d;
      parity_evt = pe; chan_evt = ce; refresh_tick = rt; tmr2_out = t2;
      @(posedge clk);
      if (w && a == 10'h061) begin
         if (!pe && d[2]) m_par = 1'b0;
         if (!ce && d[3]) m_chk = 1'b0;
         m_ctrl = d[3:0];
      end
      if (w && a == 10'h070) m_dis = d[7];
      if (pe) m_par = 1'b1;
      if (ce) m_chk = 1'b1;
      if (rt) m_tgl = ~m_tgl;
      @(negedge clk);
      check_all();
   endtask

   task automatic rd(input logic [9:0] a);
      io_addr = a; io_wr = 1'b0; #1;
      chk(io_rdata == exp_rd(a), (a == 10'h070) ? "R9" : (a == 10'h061) ? "R2" : "R10",
          io_rdata, exp_rd(a));
   endtask

   initial begin
      #(20 * 150000);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      m_ctrl = '0; m_par = 0; m_chk = 0; m_tgl = 0; m_dis = 1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      chk(nmi_out == 1'b0, "R1", {7'b0, nmi_out}, 8'h00);
      rd(10'h061); chk(io_rdata[3:0] == 4'h0, "R1", io_rdata, 8'h00);
      rd(10'h070); chk(io_rdata == 8'h80, "R1", io_rdata, 8'h80);
      // R2 high nibble ignored on write
      step(10'h061, 1, 8'hF3, 0, 0, 0, 1); rd(10'h061);
      // R5 latch, masked by master
      step(10'h061, 1, 8'h04, 1, 0, 0, 0);
      step(10'h000, 0, 8'h00, 0, 0, 0, 0);
      chk(nmi_out == 1'b0, "R8 master blocks", {7'b0, nmi_out}, 8'h00);
      step(10'h070, 1, 8'h00, 0, 0, 0, 0);   // unmask: nmi rises
      chk(nmi_out == 1'b1, "R8 unmask", {7'b0, nmi_out}, 8'h01);
      // R5 set beats clear in same cycle
      step(10'h061, 1, 8'h04, 1, 0, 0, 0); rd(10'h061);
      // R6 channel check, same-cycle priority then clear
      step(10'h061, 1, 8'h08, 0, 1, 0, 0);
      step(10'h061, 1, 8'h08, 0, 0, 0, 0); rd(10'h061);
      // R10 other address write ignored
      step(10'h062, 1, 8'hFF, 0, 0, 0, 1); rd(10'h061); rd(10'h070); rd(10'h1FF);
      // R7 refresh toggles
      step(10'h061, 0, 8'h00, 0, 0, 1, 1);
      step(10'h061, 0, 8'h00, 0, 0, 1, 0);
      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [9:0] a;
         int sel = $urandom_range(0, 5);
         a = (sel < 3) ? 10'h061 : (sel < 5) ? 10'h070 : 10'($urandom);
         step(a, ($urandom_range(0, 2) == 0), 8'($urandom),
              ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 3) == 0), 1'($urandom));
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule